// File: doc/BRIEF.md
# Protected Flash Command Sequencer

This block sits behind the control and bus pins of a byte-wide parallel flash. It turns qualified write cycles into commands for the array controller. Unlock writes must come first, and they must arrive in a fixed order. Only then does the block accept a program, a sector erase, a block erase, a whole-chip erase or entry into identification mode. Any write that breaks the order drops the sequence back to the start, and no command is issued.

The active-low pins for reset, output enable and write enable are sampled by the system clock through a synchronizer. A write counts only when all of the following hold:
- the write-enable low pulse lasts at least `MIN_LOW_CYC` samples;
- output enable stays high for the whole pulse;
- the reset pin is released;
- the array controller is not busy.

Commands leave the block as one-cycle strobes, with the address and data captured from the final write.

In identification mode, reads return fixed manufacturer and device bytes. Outside that mode, read data is passed through from the array. A read-drive enable models the tri-state output buffer.

Top module: `flash_cmd_seq`

## Requirements
- R1: After system reset, every command strobe is low, `rd_oe` is low and `id_mode` is low.
- R2: The writes (0x5555, 0xAA), (0x2AAA, 0x55) and (0x5555, 0xA0), followed by one more write, produce exactly one `cmd_prog` pulse. That pulse carries the address and data of the fourth write.
- R3: The writes (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55) are followed by a final write. If the final data is 0x30, one `cmd_sec_erase` pulse is issued. If it is 0x50, one `cmd_blk_erase` pulse is issued. If it is 0x10, one `cmd_chip_erase` pulse is issued. In each case `cmd_addr` is the final write's address, and any address is accepted for a chip erase.
- R4: A qualified write that does not match the expected address/data pair returns the sequence to its start without a strobe. This includes an unknown final erase byte. A complete correct sequence that follows it is accepted.
- R5: A write-enable low pulse shorter than `MIN_LOW_CYC` (default 3) clock samples is ignored, and the sequence position is left unchanged. A pulse of exactly `MIN_LOW_CYC` samples is accepted.
- R6: A write pulse during which output enable is low is ignored.
- R7: A write that completes while `array_busy` is high is ignored, and the sequence position is left unchanged. No strobe is issued while the controller is busy.
- R8: The writes (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x90) set `id_mode`. In that mode the read data depends on the address:
  - all address bits zero returns 0xBF;
  - only bit 0 set returns 0x60;
  - any other address returns 0x00.
- R9: Outside the program data phase, a write of 0xF0 at any address clears `id_mode`. The read data then follows `array_rd_data`.
- R10: While the reset pin is low, writes are ignored, the sequence returns to its start, `id_mode` clears and `rd_oe` is low.
- R11: `rd_oe` is high only while reset is released, output enable is low and write enable is high. Outside identification mode, `rd_data` equals `array_rd_data`.
- R12: Each command strobe is high for a single cycle, and at most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| pin_rst_n | input | 1 | Asynchronous reset pin, active low |
| pin_oe_n | input | 1 | Asynchronous output-enable pin, active low |
| pin_we_n | input | 1 | Asynchronous write-enable pin, active low |
| addr | input | AW | Address bus |
| wdata | input | 8 | Write data bus |
| array_busy | input | 1 | Array controller is executing a command |
| array_rd_data | input | 8 | Read data from the array |
| cmd_prog | output | 1 | Program strobe |
| cmd_sec_erase | output | 1 | Sector erase strobe |
| cmd_blk_erase | output | 1 | Block erase strobe |
| cmd_chip_erase | output | 1 | Chip erase strobe |
| cmd_addr | output | AW | Address for the issued command |
| cmd_data | output | 8 | Data for the issued command |
| id_mode | output | 1 | Identification mode active |
| rd_data | output | 8 | Read data |
| rd_oe | output | 1 | Read-drive enable; low means the bus is released |

## Verification
The assertions assume three things about the inputs:
- Address and write data are held steady for the whole write-enable low pulse.
- Write pulses are spaced several clocks apart, so two strobes can never land on adjacent cycles.
- `array_busy` does not change during a write pulse.

The bench drives every pin on the falling clock edge and holds address and data from one cycle before each pulse until six cycles after it. It changes `array_busy` only between writes, and it waits long enough after each write for the synchronizer and the strobe register to settle.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_GOT_AA,
    SQ_GOT_55,
    SQ_PROG_DATA,
    SQ_ERS_SETUP,
    SQ_ERS_AA,
    SQ_ERS_55
  } seq_state_t;

  localparam logic [7:0] BYTE_UNLK1   = 8'hAA;
  localparam logic [7:0] BYTE_UNLK2   = 8'h55;
  localparam logic [7:0] BYTE_PROG    = 8'hA0;
  localparam logic [7:0] BYTE_ERS     = 8'h80;
  localparam logic [7:0] BYTE_ID      = 8'h90;
  localparam logic [7:0] BYTE_EXIT    = 8'hF0;
  localparam logic [7:0] BYTE_SECTOR  = 8'h30;
  localparam logic [7:0] BYTE_BLOCK   = 8'h50;
  localparam logic [7:0] BYTE_CHIP    = 8'h10;

endpackage

// File: rtl/fsq_pin_sync.sv
module fsq_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/fsq_wr_qual.sv
module fsq_wr_qual #(
  parameter int AW          = 19,
  parameter int MIN_LOW_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_s,
  input  logic          oe_s,
  input  logic          rst_ok,
  input  logic          busy,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  localparam int CW = (MIN_LOW_CYC < 2) ? 1 : $clog2(MIN_LOW_CYC + 1);
  localparam logic [CW-1:0] CNT_MIN = CW'(MIN_LOW_CYC);

  logic          we_q;
  logic [CW-1:0] low_cnt;
  logic          spoiled;
  logic          spoil_now;

  assign spoil_now = !oe_s || !rst_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b1;
      low_cnt <= '0;
      spoiled <= 1'b0;
      wr_evt  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      we_q   <= we_s;
      wr_evt <= 1'b0;
      if (!we_s) begin
        wr_addr <= addr;
        wr_data <= wdata;
        if (we_q) begin
          low_cnt <= CW'(1);
          spoiled <= spoil_now;
        end else begin
          if (low_cnt < CNT_MIN) low_cnt <= low_cnt + 1'b1;
          spoiled <= spoiled | spoil_now;
        end
      end else if (!we_q) begin
        wr_evt  <= (low_cnt >= CNT_MIN) && !spoiled && !spoil_now && !busy;
        low_cnt <= '0;
        spoiled <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fsq_cmd_fsm.sv
module fsq_cmd_fsm
  import flash_seq_pkg::*;
#(
  parameter int            AW       = 19,
  parameter logic [AW-1:0] UNLK_A1  = AW'('h5555),
  parameter logic [AW-1:0] UNLK_A2  = AW'('h2AAA)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rst_ok,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic          cmd_prog,
  output logic          cmd_sec_erase,
  output logic          cmd_blk_erase,
  output logic          cmd_chip_erase,
  output logic [AW-1:0] cmd_addr,
  output logic [7:0]    cmd_data,
  output logic          id_mode
);
  seq_state_t state, state_nx;
  logic       id_nx;
  logic       prog_nx, sec_nx, blk_nx, chip_nx;
  logic       at_a1, at_a2;

  assign at_a1 = (wr_addr == UNLK_A1);
  assign at_a2 = (wr_addr == UNLK_A2);

  always_comb begin
    state_nx = state;
    id_nx    = id_mode;
    prog_nx  = 1'b0;
    sec_nx   = 1'b0;
    blk_nx   = 1'b0;
    chip_nx  = 1'b0;
    if (wr_evt) begin
      if (state != SQ_PROG_DATA && wr_data == BYTE_EXIT) begin
        id_nx    = 1'b0;
        state_nx = SQ_IDLE;
      end else begin
        state_nx = SQ_IDLE;
        unique case (state)
          SQ_IDLE:
            if (at_a1 && wr_data == BYTE_UNLK1) state_nx = SQ_GOT_AA;
          SQ_GOT_AA:
            if (at_a2 && wr_data == BYTE_UNLK2) state_nx = SQ_GOT_55;
          SQ_GOT_55:
            if (at_a1) begin
              if (wr_data == BYTE_PROG)     state_nx = SQ_PROG_DATA;
              else if (wr_data == BYTE_ERS) state_nx = SQ_ERS_SETUP;
              else if (wr_data == BYTE_ID)  id_nx    = 1'b1;
            end
          SQ_PROG_DATA:
            prog_nx = 1'b1;
          SQ_ERS_SETUP:
            if (at_a1 && wr_data == BYTE_UNLK1) state_nx = SQ_ERS_AA;
          SQ_ERS_AA:
            if (at_a2 && wr_data == BYTE_UNLK2) state_nx = SQ_ERS_55;
          SQ_ERS_55: begin
            sec_nx  = (wr_data == BYTE_SECTOR);
            blk_nx  = (wr_data == BYTE_BLOCK);
            chip_nx = (wr_data == BYTE_CHIP);
          end
          default: state_nx = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rst_ok) begin
      state          <= SQ_IDLE;
      id_mode        <= 1'b0;
      cmd_prog       <= 1'b0;
      cmd_sec_erase  <= 1'b0;
      cmd_blk_erase  <= 1'b0;
      cmd_chip_erase <= 1'b0;
      cmd_addr       <= '0;
      cmd_data       <= '0;
    end else begin
      state          <= state_nx;
      id_mode        <= id_nx;
      cmd_prog       <= prog_nx;
      cmd_sec_erase  <= sec_nx;
      cmd_blk_erase  <= blk_nx;
      cmd_chip_erase <= chip_nx;
      if (prog_nx || sec_nx || blk_nx || chip_nx) begin
        cmd_addr <= wr_addr;
        cmd_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/fsq_rd_path.sv
module fsq_rd_path #(
  parameter int         AW     = 19,
  parameter logic [7:0] ID_MFR = 8'hBF,
  parameter logic [7:0] ID_DEV = 8'h60
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rst_ok,
  input  logic          oe_s,
  input  logic          we_s,
  input  logic          id_mode,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    array_rd_data,
  output logic [7:0]    rd_data,
  output logic          rd_oe
);
  logic [7:0] id_byte;

  always_comb begin
    if (addr[AW-1:1] != '0) id_byte = 8'h00;
    else if (addr[0])       id_byte = ID_DEV;
    else                    id_byte = ID_MFR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_oe   <= 1'b0;
    end else begin
      rd_oe   <= rst_ok && !oe_s && we_s;
      rd_data <= id_mode ? id_byte : array_rd_data;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW          = 19,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_rst_n,
  input  logic          pin_oe_n,
  input  logic          pin_we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          array_busy,
  input  logic [7:0]    array_rd_data,
  output logic          cmd_prog,
  output logic          cmd_sec_erase,
  output logic          cmd_blk_erase,
  output logic          cmd_chip_erase,
  output logic [AW-1:0] cmd_addr,
  output logic [7:0]    cmd_data,
  output logic          id_mode,
  output logic [7:0]    rd_data,
  output logic          rd_oe
);
  logic          rst_ok, oe_s, we_s;
  logic          wr_evt;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  fsq_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_rst (
    .clk(clk), .rst(rst), .din(pin_rst_n), .dout(rst_ok));
  fsq_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_oe (
    .clk(clk), .rst(rst), .din(pin_oe_n), .dout(oe_s));
  fsq_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_we (
    .clk(clk), .rst(rst), .din(pin_we_n), .dout(we_s));

  fsq_wr_qual #(.AW(AW), .MIN_LOW_CYC(MIN_LOW_CYC)) u_qual (
    .clk(clk), .rst(rst), .we_s(we_s), .oe_s(oe_s), .rst_ok(rst_ok),
    .busy(array_busy), .addr(addr), .wdata(wdata),
    .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data));

  fsq_cmd_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst(rst), .rst_ok(rst_ok), .wr_evt(wr_evt),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_prog(cmd_prog), .cmd_sec_erase(cmd_sec_erase),
    .cmd_blk_erase(cmd_blk_erase), .cmd_chip_erase(cmd_chip_erase),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .id_mode(id_mode));

  fsq_rd_path #(.AW(AW)) u_rd (
    .clk(clk), .rst(rst), .rst_ok(rst_ok), .oe_s(oe_s), .we_s(we_s),
    .id_mode(id_mode), .addr(addr), .array_rd_data(array_rd_data),
    .rd_data(rd_data), .rd_oe(rd_oe));
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst,
  input logic          pin_rst_n,
  input logic [AW-1:0] addr,
  input logic          array_busy,
  input logic          cmd_prog,
  input logic          cmd_sec_erase,
  input logic          cmd_blk_erase,
  input logic          cmd_chip_erase,
  input logic          id_mode,
  input logic [7:0]    rd_data,
  input logic          rd_oe
);
  logic any_cmd;
  assign any_cmd = cmd_prog | cmd_sec_erase | cmd_blk_erase | cmd_chip_erase;

  assert_strobe_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_prog, cmd_sec_erase, cmd_blk_erase, cmd_chip_erase}));

  assert_strobe_single_R12: assert property (@(posedge clk) disable iff (rst)
    any_cmd |=> !any_cmd);

  assert_no_cmd_busy_R7: assert property (@(posedge clk) disable iff (rst)
    $past(array_busy, 2) |-> !any_cmd);

  assert_id_mfr_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(id_mode) && $past(addr) == '0) |-> rd_data == 8'hBF);

  assert_id_dev_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(id_mode) && $past(addr) == AW'(1)) |-> rd_data == 8'h60);

  assert_pin_reset_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(pin_rst_n, 1) && !$past(pin_rst_n, 2) && !$past(pin_rst_n, 3))
      |-> (!rd_oe && !id_mode && !any_cmd));
endmodule

bind flash_cmd_seq fsq_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .pin_rst_n(pin_rst_n), .addr(addr),
  .array_busy(array_busy), .cmd_prog(cmd_prog),
  .cmd_sec_erase(cmd_sec_erase), .cmd_blk_erase(cmd_blk_erase),
  .cmd_chip_erase(cmd_chip_erase), .id_mode(id_mode),
  .rd_data(rd_data), .rd_oe(rd_oe));

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pin_rst_n = 1'b1, pin_oe_n = 1'b1, pin_we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic          array_busy = 1'b0;
  logic [7:0]    array_rd_data = 8'hC3;
  logic          cmd_prog, cmd_sec_erase, cmd_blk_erase, cmd_chip_erase;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic          id_mode;
  logic [7:0]    rd_data;
  logic          rd_oe;

  int n_vec = 0, n_bad = 0;
  int n_prog = 0, n_sec = 0, n_blk = 0, n_chip = 0;
  int strobe_err = 0;
  logic [AW-1:0] last_addr = '0;
  logic [7:0]    last_data = '0;
  logic          prev_any = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_seq #(.AW(AW)) u0 (.*);

  always @(posedge clk) begin
    if (!rst) begin
      if (cmd_prog)       n_prog++;
      if (cmd_sec_erase)  n_sec++;
      if (cmd_blk_erase)  n_blk++;
      if (cmd_chip_erase) n_chip++;
      if (cmd_prog || cmd_sec_erase || cmd_blk_erase || cmd_chip_erase) begin
        last_addr = cmd_addr;
        last_data = cmd_data;
      end
      if ((cmd_prog + cmd_sec_erase + cmd_blk_erase + cmd_chip_erase) > 1) strobe_err++;
      if (prev_any && (cmd_prog | cmd_sec_erase | cmd_blk_erase | cmd_chip_erase)) strobe_err++;
      prev_any = cmd_prog | cmd_sec_erase | cmd_blk_erase | cmd_chip_erase;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                    input int w = 4, input bit oe_low = 1'b0);
    @(negedge clk); addr = a; wdata = d;
    @(negedge clk); pin_we_n = 1'b0; if (oe_low) pin_oe_n = 1'b0;
    repeat (w) @(negedge clk);
    pin_we_n = 1'b1; pin_oe_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic unlock(input logic [7:0] c, input int w = 4);
    wr(AW'('h5555), 8'hAA, w);
    wr(AW'('h2AAA), 8'h55, w);
    wr(AW'('h5555), c, w);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); addr = a; pin_oe_n = 1'b0;
    repeat (5) @(negedge clk);
    d = rd_data; oe = rd_oe;
    pin_oe_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic int total();
    return n_prog + n_sec + n_blk + n_chip;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check(!rd_oe && !id_mode && !cmd_prog && !cmd_sec_erase && !cmd_blk_erase && !cmd_chip_erase,
          "R1 reset state", {rd_oe, id_mode}, 0);
  endtask

  task automatic t_program();
    int p = n_prog;
    unlock(8'hA0);
    wr(AW'('h12345), 8'h5A);
    check(n_prog == p + 1, "R2 program strobe count", n_prog - p, 1);
    check(last_addr == AW'('h12345) && last_data == 8'h5A, "R2 program addr/data",
          {last_addr, last_data}, {AW'('h12345), 8'h5A});
  endtask

  task automatic t_erase(input logic [7:0] code, input logic [AW-1:0] a);
    int s = n_sec, b = n_blk, c = n_chip;
    unlock(8'h80);
    wr(AW'('h5555), 8'hAA);
    wr(AW'('h2AAA), 8'h55);
    wr(a, code);
    check(n_sec - s == (code == 8'h30 ? 1 : 0), "R3 sector erase count", n_sec - s, code == 8'h30);
    check(n_blk - b == (code == 8'h50 ? 1 : 0), "R3 block erase count", n_blk - b, code == 8'h50);
    check(n_chip - c == (code == 8'h10 ? 1 : 0), "R3 chip erase count", n_chip - c, code == 8'h10);
    check(last_addr == a, "R3 erase address", last_addr, a);
  endtask

  task automatic t_bad_seq();
    int t = total();
    wr(AW'('h5555), 8'hAA);
    wr(AW'('h2AAA), 8'h56);
    wr(AW'('h5555), 8'hA0);
    wr(AW'('h00100), 8'h11);
    check(total() == t, "R4 broken unlock gives no command", total() - t, 0);
    unlock(8'h80);
    wr(AW'('h5555), 8'hAA);
    wr(AW'('h2AAA), 8'h55);
    wr(AW'('h10000), 8'h40);
    check(total() == t, "R4 unknown erase byte gives no command", total() - t, 0);
    t_program();
    check(total() == t + 1, "R4 correct sequence after error", total() - t, 1);
  endtask

  task automatic t_short_pulse();
    int p = n_prog;
    unlock(8'hA0, 2);
    wr(AW'('h00200), 8'h22, 2);
    check(n_prog == p, "R5 short pulses ignored", n_prog - p, 0);
    wr(AW'('h5555), 8'hAA);
    wr(AW'('h2AAA), 8'h55, 2);
    wr(AW'('h2AAA), 8'h55);
    wr(AW'('h5555), 8'hA0);
    wr(AW'('h00300), 8'h33);
    check(n_prog == p + 1, "R5 short pulse leaves position", n_prog - p, 1);
    unlock(8'hA0, 3);
    wr(AW'('h00301), 8'h34, 3);
    check(n_prog == p + 2 && last_data == 8'h34, "R5 minimum width accepted", n_prog - p, 2);
  endtask

  task automatic t_inhibit();
    int p = n_prog;
    unlock(8'hA0);
    wr(AW'('h00400), 8'h44, 4, 1'b1);
    check(n_prog == p, "R6 write with OE low inhibited", n_prog - p, 0);
    wr(AW'('h00401), 8'h45);
    check(n_prog == p + 1 && last_addr == AW'('h00401), "R6 inhibited write left position",
          n_prog - p, 1);
  endtask

  task automatic t_busy();
    int p = n_prog;
    array_busy = 1'b1;
    unlock(8'hA0);
    wr(AW'('h00500), 8'h55);
    check(n_prog == p, "R7 no command while busy", n_prog - p, 0);
    array_busy = 1'b0;
    wr(AW'('h5555), 8'hAA);
    array_busy = 1'b1;
    wr(AW'('h01234), 8'h77);
    array_busy = 1'b0;
    wr(AW'('h2AAA), 8'h55);
    wr(AW'('h5555), 8'hA0);
    wr(AW'('h00501), 8'h66);
    check(n_prog == p + 1 && last_data == 8'h66, "R7 busy write left position", n_prog - p, 1);
  endtask

  task automatic t_id();
    logic [7:0] d; logic oe;
    unlock(8'h90);
    check(id_mode, "R8 id mode entered", id_mode, 1);
    rd(AW'(0), d, oe);
    check(d == 8'hBF && oe, "R8 manufacturer byte", d, 8'hBF);
    rd(AW'(1), d, oe);
    check(d == 8'h60, "R8 device byte", d, 8'h60);
    rd(AW'('h100), d, oe);
    check(d == 8'h00, "R8 non-id address", d, 0);
    wr(AW'('h7777), 8'hF0);
    check(!id_mode, "R9 exit byte clears id mode", id_mode, 0);
    rd(AW'(0), d, oe);
    check(d == 8'hC3, "R9 array data after exit", d, 8'hC3);
  endtask

  task automatic t_normal_read();
    logic [7:0] d; logic oe;
    array_rd_data = 8'h3C;
    rd(AW'('h4444), d, oe);
    check(d == 8'h3C && oe, "R11 normal read data and drive", {oe, d}, {1'b1, 8'h3C});
    repeat (2) @(negedge clk);
    check(!rd_oe, "R11 drive released with OE high", rd_oe, 0);
    array_rd_data = 8'hC3;
  endtask

  task automatic t_pin_reset();
    int p = n_prog;
    unlock(8'h90);
    wr(AW'('h5555), 8'hAA);
    @(negedge clk); pin_rst_n = 1'b0; pin_oe_n = 1'b0;
    repeat (6) @(negedge clk);
    check(!rd_oe && !id_mode, "R10 pin reset releases bus and id", {rd_oe, id_mode}, 0);
    pin_oe_n = 1'b1;
    wr(AW'('h2AAA), 8'h55);
    @(negedge clk); pin_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(AW'('h2AAA), 8'h55);
    wr(AW'('h5555), 8'hA0);
    wr(AW'('h00600), 8'h99);
    check(n_prog == p, "R10 sequence cleared by pin reset", n_prog - p, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program();
    t_erase(8'h30, AW'('h3F000));
    t_erase(8'h50, AW'('h20000));
    t_erase(8'h10, AW'('h00123));
    t_bad_seq();
    t_short_pulse();
    t_inhibit();
    t_busy();
    t_id();
    t_normal_read();
    t_pin_reset();
    check(strobe_err == 0, "R12 strobes single and exclusive", strobe_err, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule